// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherent Cache Cluster

This block joins several per-core private data caches to one shared single-cycle bus and one backing memory. Each cache is small, direct-mapped, write-back, and one word per line. Every line is Invalid, Shared or Modified, so any address has a single writer or a group of readers, never both. A core makes a request and holds it, with its address, write flag and write data, until the cache pulses `core_done`. The core is stalled until then.

A cache goes to the bus only when it must. Read misses fetch the word. A store to a missing line fetches and invalidates in one transaction. A store to a Shared line sends a data-less invalidate. A dirty victim is written back before its replacement is fetched. Every cache watches each transaction that a peer places on the bus. A peer read of a Modified line makes the owner supply the word, write it to memory in the same cycle, and keep a Shared copy. A peer fetch-for-write or invalidate removes the watcher's copy. A round-robin arbiter grants the bus to one cache per cycle, so all writes to one address are seen in a single order.

The per-cache controller is an FSM. Its states are `CS_IDLE`, `CS_WBACK`, `CS_BUS` and `CS_RESP`, with these transitions:
- IDLE→RESP on a read hit or on a store hit to a Modified line.
- IDLE→WBACK on a miss whose victim is Modified.
- IDLE→BUS on any other miss, or on a store to a Shared line.
- WBACK→BUS when granted.
- BUS→RESP when granted.
- RESP→IDLE always.
- IDLE stays in IDLE while a peer transaction targets the same set.

Top module: `snoop_inval_cluster`

## Requirements
- R1: After reset every line is Invalid, memory holds zero, `core_done` and `bus_grant` are low, and `bus_cmd` is 0 (none). The first read of any address returns 0.
- R2: A read that hits a Shared or Modified line pulses `core_done` 1 cycle after the request is sampled and puts no command on the bus.
- R3: A read miss with a clean or empty victim issues read (`bus_cmd`=1) and completes 2 cycles after the request. It returns the current value and leaves the line Shared.
- R4: A store to a Modified line completes in 1 cycle with no bus command. A store to a Shared line issues invalidate (`bus_cmd`=3) and completes in 2 cycles. A store miss issues read-for-ownership (`bus_cmd`=2) and completes in 2 cycles. Each of these leaves the line Modified.
- R5: When a peer reads a line this cache holds Modified, this cache supplies the word, memory is written with it in the same cycle, and this copy becomes Shared.
- R6: A peer read-for-ownership or invalidate of a held line makes this copy Invalid. The next read of it here misses and returns the owner's value.
- R7: For any address, at most one cache holds it Modified, and then no other cache holds it at all.
- R8: A miss whose victim is Modified first issues write-back (`bus_cmd`=4) with the victim's address and data. The refill follows on the next grant, and the miss completes 3 cycles after the request.
- R9: At most one cache is granted per cycle, and only a requester is granted. After cache i is granted, cache i+1 (modulo the count) has the highest priority.
- R10: Stores to one address from several cores take effect in grant order, and afterwards all cores read the same final value.
- R11: `core_done` is a one-cycle pulse per request.
- R12: A request whose set is being snooped by a peer transaction in the same cycle waits one cycle before it is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | NCORE | Per-core request, held until done |
| core_we | input | NCORE | Per-core store flag |
| core_addr | input | NCORE*AW | Per-core word address, core i at [i*AW +: AW] |
| core_wdata | input | NCORE*DW | Per-core store data |
| core_done | output | NCORE | Per-core completion pulse |
| core_rdata | output | NCORE*DW | Per-core read result, valid with done |
| bus_grant | output | NCORE | One-hot bus owner this cycle |
| bus_cmd | output | 3 | Bus command: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bus_addr | output | AW | Bus address this cycle |

## Verification
Results are due at fixed cycle counts measured from the clock edge that first samples a request:
- a hit, 1 cycle;
- a clean miss or an invalidate, 2 cycles;
- a dirty-victim miss, 3 cycles;
- one extra cycle for each earlier grant to a peer, or for a same-set snoop in the cycle of arrival.

The driver stamps the cycle number into each expected item, and the monitor compares that stamp with the cycle on which `core_done` appears. Bus commands are logged per owner at the falling edge and compared in order after each operation. Together these show the data path and the coherence traffic.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_MOD = 2'b10
    } line_st_e;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_UPGR = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_WBACK,
        CS_BUS,
        CS_RESP
    } ctl_st_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] prio_q;
    logic [IW-1:0] win;

    always_comb begin
        gnt = '0;
        win = '0;
        for (int k = 0; k < N; k++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(prio_q) + k) % N);
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= '0;
        else if (gnt != '0)
            prio_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R9
    AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R9
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 8,
    parameter int SETS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output bus_cmd_e      own_cmd,
    output logic [AW-1:0] own_addr,
    output logic [DW-1:0] own_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  bus_cmd_e      snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_flush,
    output logic [DW-1:0] snp_data,
    output logic          snp_has_mod,
    output logic          snp_has_any
);
    localparam int IW = $clog2(SETS);
    localparam int TW = AW - IW;

    line_st_e      st_q  [SETS];
    logic [TW-1:0] tag_q [SETS];
    logic [DW-1:0] dat_q [SETS];
    logic [DW-1:0] rdata_q;
    ctl_st_e       cs_q, cs_d;

    logic [IW-1:0] r_idx, s_idx;
    logic [TW-1:0] r_tag, s_tag;
    logic          tag_hit, victim_dirty, snp_match, snp_block, wr_hit_mod;

    assign r_idx = core_addr[IW-1:0];
    assign r_tag = core_addr[AW-1:IW];
    assign s_idx = snp_addr[IW-1:0];
    assign s_tag = snp_addr[AW-1:IW];

    assign tag_hit      = (st_q[r_idx] != LN_INV) && (tag_q[r_idx] == r_tag);
    assign victim_dirty = (st_q[r_idx] == LN_MOD) && (tag_q[r_idx] != r_tag);
    assign snp_has_any  = (st_q[s_idx] != LN_INV) && (tag_q[s_idx] == s_tag);
    assign snp_has_mod  = (st_q[s_idx] == LN_MOD) && (tag_q[s_idx] == s_tag);
    assign snp_match    = (snp_cmd != BC_NONE) && snp_has_any;
    assign snp_block    = (snp_cmd != BC_NONE) && (s_idx == r_idx);
    assign snp_flush    = snp_has_mod && (snp_cmd == BC_RD || snp_cmd == BC_RDX);
    assign snp_data     = dat_q[s_idx];
    assign wr_hit_mod   = core_we && tag_hit && (st_q[r_idx] == LN_MOD);

    // next-state process
    always_comb begin
        cs_d = cs_q;
        unique case (cs_q)
            CS_IDLE:
                if (core_req && !snp_block) begin
                    if (tag_hit && (!core_we || st_q[r_idx] == LN_MOD)) cs_d = CS_RESP;
                    else if (victim_dirty)                              cs_d = CS_WBACK;
                    else                                                cs_d = CS_BUS;
                end
            CS_WBACK: if (bus_gnt) cs_d = CS_BUS;
            CS_BUS:   if (bus_gnt) cs_d = CS_RESP;
            CS_RESP:  cs_d = CS_IDLE;
        endcase
    end

    // output process
    always_comb begin
        bus_req   = (cs_q == CS_WBACK) || (cs_q == CS_BUS);
        own_cmd   = BC_NONE;
        own_addr  = core_addr;
        own_wdata = dat_q[r_idx];
        core_done = (cs_q == CS_RESP);
        unique case (cs_q)
            CS_WBACK: begin
                own_addr = {tag_q[r_idx], r_idx};
                if (bus_gnt && st_q[r_idx] == LN_MOD) own_cmd = BC_WB;
            end
            CS_BUS:
                if (bus_gnt) begin
                    if (!core_we)     own_cmd = BC_RD;
                    else if (tag_hit) own_cmd = BC_UPGR;
                    else              own_cmd = BC_RDX;
                end
            default: ;
        endcase
    end

    assign core_rdata = rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= CS_IDLE;
        else        cs_q <= cs_d;
    end

    // line array: snoop effects, then own effects (never the same set)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (snp_match) begin
                case (snp_cmd)
                    BC_RD:           st_q[s_idx] <= LN_SHR;
                    BC_RDX, BC_UPGR: st_q[s_idx] <= LN_INV;
                    default: ;
                endcase
            end
            if (cs_q == CS_IDLE && core_req && !snp_block && tag_hit) begin
                if (wr_hit_mod) begin
                    dat_q[r_idx] <= core_wdata;
                    rdata_q      <= core_wdata;
                end else if (!core_we) begin
                    rdata_q <= dat_q[r_idx];
                end
            end
            if (bus_gnt && cs_q == CS_WBACK) st_q[r_idx] <= LN_INV;
            if (bus_gnt && cs_q == CS_BUS) begin
                tag_q[r_idx] <= r_tag;
                if (core_we) begin
                    st_q[r_idx]  <= LN_MOD;
                    dat_q[r_idx] <= core_wdata;
                    rdata_q      <= core_wdata;
                end else begin
                    st_q[r_idx]  <= LN_SHR;
                    dat_q[r_idx] <= bus_rdata;
                    rdata_q      <= bus_rdata;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done); // R11
    AST_NO_DIRTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (own_cmd == BC_RD || own_cmd == BC_RDX) |-> !victim_dirty); // R8
    AST_STORE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == CS_RESP && $past(core_we)) |-> (st_q[r_idx] == LN_MOD && tag_q[r_idx] == r_tag)); // R4
    AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_match && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR)) |=> st_q[$past(s_idx)] == LN_INV); // R6
    AST_SNOOP_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && snp_cmd == BC_RD) |=> st_q[$past(s_idx)] == LN_SHR); // R5
endmodule

// File: rtl/snoop_inval_cluster.sv
module snoop_inval_cluster
    import coh_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int SETS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    core_req,
    input  logic [NCORE-1:0]    core_we,
    input  logic [NCORE*AW-1:0] core_addr,
    input  logic [NCORE*DW-1:0] core_wdata,
    output logic [NCORE-1:0]    core_done,
    output logic [NCORE*DW-1:0] core_rdata,
    output logic [NCORE-1:0]    bus_grant,
    output logic [2:0]          bus_cmd,
    output logic [AW-1:0]       bus_addr
);
    localparam int MDEPTH = 1 << AW;

    logic [NCORE-1:0] breq, flush, has_mod, has_any;
    bus_cmd_e         own_cmd_a [NCORE];
    bus_cmd_e         snp_cmd_a [NCORE];
    logic [AW-1:0]    own_addr_a [NCORE];
    logic [DW-1:0]    own_wd_a   [NCORE];
    logic [DW-1:0]    snp_data_a [NCORE];
    logic [DW-1:0]    mem_q [MDEPTH];

    logic [2:0]    cmd_acc;
    logic [AW-1:0] addr_acc;
    logic [DW-1:0] wd_acc, fl_acc, bus_rdata;
    logic          fl_any;
    bus_cmd_e      bus_cmd_w;

    coh_rr_arb #(.N(NCORE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(breq), .gnt(bus_grant)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_cache
        assign snp_cmd_a[g] = bus_grant[g] ? BC_NONE : bus_cmd_w;
        coh_line_ctrl #(.AW(AW), .DW(DW), .SETS(SETS)) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .core_req   (core_req[g]),
            .core_we    (core_we[g]),
            .core_addr  (core_addr[g*AW +: AW]),
            .core_wdata (core_wdata[g*DW +: DW]),
            .core_done  (core_done[g]),
            .core_rdata (core_rdata[g*DW +: DW]),
            .bus_req    (breq[g]),
            .bus_gnt    (bus_grant[g]),
            .own_cmd    (own_cmd_a[g]),
            .own_addr   (own_addr_a[g]),
            .own_wdata  (own_wd_a[g]),
            .bus_rdata  (bus_rdata),
            .snp_cmd    (snp_cmd_a[g]),
            .snp_addr   (bus_addr),
            .snp_flush  (flush[g]),
            .snp_data   (snp_data_a[g]),
            .snp_has_mod(has_mod[g]),
            .snp_has_any(has_any[g])
        );
    end

    always_comb begin
        cmd_acc  = '0;
        addr_acc = '0;
        wd_acc   = '0;
        fl_acc   = '0;
        fl_any   = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            if (bus_grant[i]) begin
                cmd_acc  = cmd_acc  | own_cmd_a[i];
                addr_acc = addr_acc | own_addr_a[i];
                wd_acc   = wd_acc   | own_wd_a[i];
            end
            if (flush[i]) begin
                fl_any = 1'b1;
                fl_acc = fl_acc | snp_data_a[i];
            end
        end
    end

    assign bus_cmd_w = bus_cmd_e'(cmd_acc);
    assign bus_cmd   = cmd_acc;
    assign bus_addr  = addr_acc;
    assign bus_rdata = fl_any ? fl_acc : mem_q[bus_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MDEPTH; i++) mem_q[i] <= '0;
        end else if (bus_cmd_w == BC_WB) begin
            mem_q[bus_addr] <= wd_acc;
        end else if (fl_any) begin
            mem_q[bus_addr] <= fl_acc;
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(has_mod)); // R7
    AST_MOD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (has_mod != '0) |-> ($countones(has_any) == 1)); // R7
    AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush)); // R5
endmodule

// File: tb/snoop_inval_cluster_bench.sv
module snoop_inval_cluster_bench;
    localparam int NC = 2;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NC-1:0]    core_req, core_we, core_done, bus_grant;
    logic [NC*AW-1:0] core_addr;
    logic [NC*DW-1:0] core_wdata, core_rdata;
    logic [2:0]       bus_cmd;
    logic [AW-1:0]    bus_addr;

    logic          req_a [NC];
    logic          we_a  [NC];
    logic [AW-1:0] addr_a[NC];
    logic [DW-1:0] wd_a  [NC];
    logic [DW-1:0] last_rd [NC];

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            core_req[i]             = req_a[i];
            core_we[i]              = we_a[i];
            core_addr[i*AW +: AW]   = addr_a[i];
            core_wdata[i*DW +: DW]  = wd_a[i];
        end
    end

    snoop_inval_cluster #(.NCORE(NC), .AW(AW), .DW(DW), .SETS(4)) u_snoop_inval_cluster (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata), .bus_grant(bus_grant), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr)
    );

    typedef struct {
        logic [DW-1:0] data;
        bit            chk;
        int            lat;
        int            rq;
        int            start;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int   log_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input int rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear, logs bus traffic
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cmd != 3'd0) log_q.push_back((bus_grant[1] ? 8 : 0) + int'(bus_cmd));
            for (int c = 0; c < NC; c++) begin
                if (core_done[c]) begin
                    exp_t e;
                    logic [DW-1:0] rd;
                    rd = core_rdata[c*DW +: DW];
                    last_rd[c] = rd;
                    if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
                        check(1'b0, 11, 1, 0);
                    end else begin
                        e = (c == 0) ? q0.pop_front() : q1.pop_front();
                        check((cyc - e.start) == e.lat, e.rq, cyc - e.start, e.lat);
                        if (e.chk) check(rd == e.data, e.rq, rd, e.data);
                    end
                end
            end
        end
    end

    // driver: queue expectation, hold request until done, then check the pulse ended
    task automatic drive(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit chk,
                         input logic [DW-1:0] exp_d, input int lat, input int rq);
        exp_t e;
        e.data = exp_d; e.chk = chk; e.lat = lat; e.rq = rq; e.start = cyc;
        if (c == 0) q0.push_back(e); else q1.push_back(e);
        we_a[c] = we; addr_a[c] = a; wd_a[c] = d; req_a[c] = 1'b1;
        do @(negedge clk); while (!core_done[c]);
        req_a[c] = 1'b0;
        @(negedge clk);
        check(core_done[c] == 1'b0, 11, core_done[c], 0); // R11
    endtask

    task automatic expect_log(input int n, input int e0, input int e1, input int rq);
        check(log_q.size() == n, rq, log_q.size(), n);
        if (n > 0 && log_q.size() > 0) check(log_q[0] == e0, rq, log_q[0], e0);
        if (n > 1 && log_q.size() > 1) check(log_q[1] == e1, rq, log_q[1], e1);
        log_q.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            req_a[i] = 1'b0; we_a[i] = 1'b0; addr_a[i] = '0; wd_a[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(core_done == '0, 1, core_done, 0);
        check(bus_cmd == 3'd0, 1, bus_cmd, 0);
        check(bus_grant == '0, 1, bus_grant, 0);
        log_q.delete();

        // R1 R3: first read misses, memory zero
        drive(0, 0, 4'h5, 8'h00, 1, 8'h00, 2, 3); expect_log(1, 1, 0, 3);
        // R2: read hit
        drive(0, 0, 4'h5, 8'h00, 1, 8'h00, 1, 2); expect_log(0, 0, 0, 2);
        // R4: store to Shared sends invalidate
        drive(0, 1, 4'h5, 8'hA1, 0, 8'h00, 2, 4); expect_log(1, 3, 0, 4);
        // R4: store to Modified stays local
        drive(0, 1, 4'h5, 8'hA2, 0, 8'h00, 1, 4); expect_log(0, 0, 0, 4);
        // R5: peer read gets owner's data
        drive(1, 0, 4'h5, 8'h00, 1, 8'hA2, 2, 5); expect_log(1, 9, 0, 5);
        // R5: owner dropped to Shared: hit read, then store needs invalidate
        drive(0, 0, 4'h5, 8'h00, 1, 8'hA2, 1, 5);
        drive(0, 1, 4'h5, 8'hA3, 0, 8'h00, 2, 5); expect_log(1, 3, 0, 5);
        // R6: invalidated copy misses and sees the new value
        drive(1, 0, 4'h5, 8'h00, 1, 8'hA3, 2, 6); expect_log(1, 9, 0, 6);
        // R5: memory was updated by the supply; evict both and reload
        drive(0, 0, 4'h1, 8'h00, 1, 8'h00, 2, 3);
        drive(1, 0, 4'h9, 8'h00, 1, 8'h00, 2, 3);
        drive(0, 0, 4'h5, 8'h00, 1, 8'hA3, 2, 5);
        log_q.delete();
        // R4: store miss uses read-for-ownership
        drive(1, 1, 4'hD, 8'h3C, 0, 8'h00, 2, 4); expect_log(1, 10, 0, 4);
        // R8: dirty victim written back before refill
        drive(1, 0, 4'h1, 8'h00, 1, 8'h00, 3, 8); expect_log(2, 12, 9, 8);
        drive(0, 0, 4'hD, 8'h00, 1, 8'h3C, 2, 8); expect_log(1, 1, 0, 8);
        // R6: read-for-ownership and invalidate remove peer copies
        drive(0, 1, 4'h2, 8'h77, 0, 8'h00, 2, 6);
        drive(1, 0, 4'h2, 8'h00, 1, 8'h77, 2, 6);
        drive(0, 1, 4'h2, 8'h78, 0, 8'h00, 2, 6);
        drive(1, 0, 4'h2, 8'h00, 1, 8'h78, 2, 6);
        // R9: round-robin order after a grant to core 0
        drive(0, 0, 4'h3, 8'h00, 1, 8'h00, 2, 9);
        fork
            drive(0, 0, 4'h7, 8'h00, 1, 8'h00, 3, 9);
            drive(1, 0, 4'hB, 8'h00, 1, 8'h00, 2, 9);
        join
        // R9: after a grant to core 1, core 0 wins
        drive(1, 0, 4'h3, 8'h00, 1, 8'h00, 2, 9);
        fork
            drive(0, 0, 4'hA, 8'h00, 1, 8'h00, 2, 9);
            drive(1, 0, 4'hE, 8'h00, 1, 8'h00, 3, 9);
        join
        // R10 R7: simultaneous stores serialize, all agree on the last
        fork
            drive(0, 1, 4'h4, 8'h11, 0, 8'h00, 2, 10);
            drive(1, 1, 4'h4, 8'h22, 0, 8'h00, 3, 10);
        join
        fork
            drive(0, 0, 4'h4, 8'h00, 1, 8'h22, 2, 10);
            drive(1, 0, 4'h4, 8'h00, 1, 8'h22, 1, 10);
        join
        check(last_rd[0] == last_rd[1], 10, last_rd[0], last_rd[1]);
        // R12: store arriving while a peer snoops its set waits a cycle
        drive(0, 1, 4'h4, 8'h55, 0, 8'h00, 2, 4);
        fork
            drive(1, 1, 4'h4, 8'h66, 0, 8'h00, 2, 12);
            begin
                @(negedge clk);
                drive(0, 1, 4'h4, 8'h77, 0, 8'h00, 3, 12);
            end
        join
        // R7: single owner supplies the final value
        drive(1, 0, 4'h4, 8'h00, 1, 8'h77, 2, 7);

        repeat (2) @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0, 11, q0.size() + q1.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule